// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Channel

This block is one timer channel that produces a symmetric, centre-aligned pulse waveform. An internal counter climbs from zero to a programmable ceiling and then falls back to zero, and repeats this as long as the timer tick is active. The running count is compared with a programmable threshold. The waveform is high while the count is below the threshold and low otherwise. As a result, the output clears when the rising count reaches the threshold and sets again when the falling count drops below it.

A two-bit output-mode field decides what reaches the two pins:
- both pins show the port-register value;
- the pins form a true/complement pair;
- only the second pin carries the true waveform;
- only the second pin carries the inverted waveform.

A pin carries the waveform only when its direction bit selects output. Otherwise it shows the port-register value.

The ceiling and threshold inputs are captured into the active registers only on the tick that leaves count zero, so each period stays symmetric. An overflow flag pulses for one clock each time the falling count arrives at zero. The counter moves only on clocks where the tick enable is high.

Top module: `cpwm_dual_slope`

## Requirements
- R1: With ceiling T > 0 and tick high on every clock, the count runs 0,1,…,T,T−1,…,1 and then returns to 0. The direction flips on the tick taken at count T.
- R2: With tick high on every clock and ceiling T > 0, consecutive overflow pulses are exactly 2·T clocks apart.
- R3: The true waveform is high exactly while count < threshold. With T=5 and threshold 3, it is high for 5 of the 10 counts in each period.
- R4: Mode 2'b00 makes pin_o equal port_i on both pins, whatever the direction bits are.
- R5: Mode 2'b01 with both direction bits high puts the true waveform on pin_o[0] and its complement on pin_o[1].
- R6: In modes 2'b10 and 2'b11, pin_o[0] equals port_i[0]. pin_o[1] carries the true waveform in mode 2'b10 and the inverted waveform in mode 2'b11.
- R7: A threshold of 0 keeps the true waveform low. A threshold above the ceiling keeps it high. An active ceiling of 0 keeps it low and holds the count at 0.
- R8: A pin whose dir_i bit is 0 shows its port_i bit in every mode.
- R9: ovf_o is high for one clock, registered, after each tick that moves the count from 1 to 0. It is never high on two consecutive clocks.
- R10: top_i and cmp_i are copied into the active registers only on a tick taken while the count is 0. Changes made at any other time take effect from the next period.
- R11: The count does not change on clocks where tick_i is low. After the asynchronous reset, the count is 0, the direction is up, the active ceiling and threshold are 0, and ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| top_i | input | CNT_W | Ceiling value, taken at count zero |
| cmp_i | input | CNT_W | Threshold value, taken at count zero |
| mode_i | input | 2 | Output mode: 00 off, 01 pair, 10 true, 11 inverted |
| dir_i | input | 2 | Per-pin output enable (direction) |
| port_i | input | 2 | Per-pin fallback port-register value |
| pin_o | output | 2 | Pin levels |
| ovf_o | output | 1 | One-clock pulse when the count reaches zero |

## Verification
A behavioural reference model is compared with both pins and the overflow flag on every clock. The ceiling/threshold pattern 5/3 runs once in each of the four output modes, which separates the cases where the first pin is wired to the port from those where it is wired to the waveform, and the true polarity from the inverted one. Thresholds of 0, of a value above the ceiling and a ceiling of 0 isolate the constant-level cases. A pseudo-random tick pattern shows that the count stalls without a tick. Changing the ceiling in mid-period, and measuring the next two overflow intervals (10 clocks, then 16), shows that new values wait for the zero point.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    OM_OFF  = 2'b00,
    OM_PAIR = 2'b01,
    OM_TRUE = 2'b10,
    OM_INV  = 2'b11
  } out_mode_e;

  localparam int unsigned NUM_PINS = 2;

  function automatic logic pin_connected(input logic [1:0] mode, input int unsigned idx);
    if (idx == 0) return mode == OM_PAIR;
    return mode != OM_OFF;
  endfunction

  function automatic logic pin_inverted(input logic [1:0] mode, input int unsigned idx);
    if (idx == 0) return 1'b0;
    return (mode == OM_PAIR) || (mode == OM_INV);
  endfunction
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] top_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, top_q, cmp_q;
  logic             up_q, up_d, ovf_q, ovf_d, load;

  assign load = tick_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    ovf_d = 1'b0;
    if (tick_i) begin
      if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = (top_i == '0) ? '0 : ONE;
      end else if (up_q && (cnt_q < top_q)) begin
        cnt_d = cnt_q + ONE;
      end else begin
        up_d  = 1'b0;
        cnt_d = cnt_q - ONE;
        ovf_d = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      top_q <= '0;
      cmp_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      ovf_q <= ovf_d;
      if (load) begin
        top_q <= top_i;
        cmp_q <= cmp_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign top_o = top_q;
  assign cmp_o = cmp_q;
  assign ovf_o = ovf_q;

  AST_CNT_LE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_q) else $error("count above ceiling"); // R1
  AST_TURN_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && up_q && (cnt_q == top_q) && (top_q != '0) |=> !up_q) else $error("no turn"); // R1
  AST_OVF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q) else $error("ovf wide"); // R9
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(top_q) && $stable(cmp_q)) else $error("early load"); // R10
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)) else $error("moved without tick"); // R11
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             wave_o
);
  // level form of clear-on-rising-match / set-on-falling-match
  assign wave_o = (top_i != '0) && (cnt_i < cmp_i);
endmodule

// File: rtl/cpwm_pin.sv
module cpwm_pin (
  input  logic wave_i,
  input  logic invert_i,
  input  logic connect_i,
  input  logic dir_i,
  input  logic port_i,
  output logic pin_o
);
  assign pin_o = (connect_i && dir_i) ? (wave_i ^ invert_i) : port_i;
endmodule

// File: rtl/cpwm_dual_slope.sv
module cpwm_dual_slope
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       dir_i,
  input  logic [1:0]       port_i,
  output logic [1:0]       pin_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt, top_act, cmp_act;
  logic             wave;

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .top_i(top_i), .cmp_i(cmp_i),
    .cnt_o(cnt), .top_o(top_act), .cmp_o(cmp_act), .ovf_o(ovf_o)
  );

  cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i(cnt), .top_i(top_act), .cmp_i(cmp_act), .wave_o(wave)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    cpwm_pin u_pin (
      .wave_i   (wave),
      .invert_i (pin_inverted(mode_i, k)),
      .connect_i(pin_connected(mode_i, k)),
      .dir_i    (dir_i[k]),
      .port_i   (port_i[k]),
      .pin_o    (pin_o[k])
    );
  end

  AST_OFF_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_OFF) |-> (pin_o == port_i)) else $error("off mode drives"); // R4
  AST_PAIR_COMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_PAIR) && (dir_i == 2'b11) |-> (pin_o[0] != pin_o[1])) else $error("pair"); // R5
  AST_PIN0_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> (pin_o[0] == port_i[0])) else $error("pin0 driven"); // R6
  AST_DIR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_i[1] |-> (pin_o[1] == port_i[1])) else $error("dir ignored"); // R8
  AST_TOP0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_act == '0) && (mode_i == OM_TRUE) && dir_i[1] |-> !pin_o[1]) else $error("top0"); // R7
endmodule

// File: tb/cpwm_dual_slope_tb.sv
module cpwm_dual_slope_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic [W-1:0] top = '0, cmp = '0;
  logic [1:0] mode = 2'b00, dir = 2'b00, port = 2'b00;
  logic [1:0] pin;
  logic ovf;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R11";
  bit running = 0, rand_tick = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_cnt = 0, m_t = 0, m_c = 0;
  bit m_up = 1, m_ovf = 0;

  always #2.5 clk = ~clk;

  cpwm_dual_slope #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .top_i(top), .cmp_i(cmp),
    .mode_i(mode), .dir_i(dir), .port_i(port), .pin_o(pin), .ovf_o(ovf)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_t = 0; m_c = 0; m_up = 1; m_ovf = 0;
    end else begin
      m_ovf = 0;
      if (tick) begin
        if (m_cnt == 0) begin
          m_t = top; m_c = cmp; m_up = 1;
          m_cnt = (m_t == 0) ? 0 : 1;
        end else if (m_up && m_cnt != m_t) begin
          m_cnt++;
        end else begin
          m_up = 0;
          m_cnt--;
          m_ovf = (m_cnt == 0);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [1:0] exp_pins();
    bit w;
    logic [1:0] p;
    w = (m_t != 0) && (m_cnt < m_c);
    p = port;
    if (mode == 2'b01 && dir[0]) p[0] = w;
    if (mode != 2'b00 && dir[1]) p[1] = (mode == 2'b10) ? w : !w;
    return p;
  endfunction

  always @(negedge clk) begin
    if (running) begin
      check({cur_req, " pins"}, pin, exp_pins());
      check("R9 ovf", ovf, m_ovf);
    end
  end

  task automatic drive(logic [W-1:0] t, logic [W-1:0] c, logic [1:0] m,
                       logic [1:0] d, logic [1:0] p, string req);
    @(posedge clk); #1;
    top = t; cmp = c; mode = m; dir = d; port = p; cur_req = req;
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk); #1;
      if (rand_tick) tick = lfsr[0];
    end
  endtask

  task automatic wait_ovf(output int at);
    do @(negedge clk); while (!ovf);
    at = cyc;
  endtask

  initial begin
    int t0, t1, t2, hi;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check("R11 reset pins", pin, 0);
    check("R11 reset ovf", ovf, 0);
    running = 1;

    // R4: off mode, ports visible
    drive(5, 3, 2'b00, 2'b11, 2'b10, "R4");
    tick = 1;
    run(40);
    // R2: period 2*T
    wait_ovf(t0); wait_ovf(t1);
    check("R2 period", t1 - t0, 10);

    // R5: complementary pair
    drive(5, 3, 2'b01, 2'b11, 2'b00, "R5");
    run(30);
    // R6: true / inverted on pin1, pin0 free; R3 duty
    drive(5, 3, 2'b10, 2'b11, 2'b01, "R6");
    run(12);
    wait_ovf(t0);
    hi = 0;
    do begin
      if (pin[1]) hi++;
      @(negedge clk);
    end while (!ovf);
    check("R3 R1 high counts per period", hi, 5);
    drive(5, 3, 2'b11, 2'b11, 2'b11, "R6");
    run(30);

    // R8: direction gates
    drive(5, 3, 2'b01, 2'b01, 2'b10, "R8");
    run(25);
    drive(5, 3, 2'b10, 2'b00, 2'b01, "R8");
    run(25);

    // R7: extremes
    drive(6, 0, 2'b10, 2'b11, 2'b01, "R7");
    run(30);
    drive(6, 9, 2'b10, 2'b11, 2'b00, "R7");
    run(30);
    drive(0, 4, 2'b10, 2'b11, 2'b01, "R7");
    run(30);
    check("R7 top0 pin1 low", pin[1], 0);

    // R10: mid-period change waits for zero
    drive(5, 2, 2'b01, 2'b11, 2'b00, "R10");
    wait_ovf(t0);
    @(posedge clk); #1 top = 8;
    wait_ovf(t1); wait_ovf(t2);
    check("R10 old period kept", t1 - t0, 10);
    check("R10 new period", t2 - t1, 16);

    // R11: gated ticks
    cur_req = "R11";
    rand_tick = 1;
    run(400);
    rand_tick = 0; tick = 1;
    run(5);

    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule